// File: doc/BRIEF.md
# Locking Packet Timestamp Latch

This block records when a precision-time packet crosses the receive or the transmit point of a network port. On the start-of-frame strobe of a qualifying packet it copies the free-running time counter into a stamp register and raises a valid flag. While the flag is up the latch is locked: every later qualifying packet on that side goes unstamped, so software can always tell which packet the held value belongs to. Reading the high word of the stamp, signalled by a one-cycle strobe, drops the flag and re-arms the latch. If a stamped packet is lost before software collects its stamp, the latch stays locked.

Receive packets are qualified by a two-bit mode and a match word. The first mode stamps version-1 UDP messages of one chosen type. The second stamps all version-2 event messages, carried either over UDP or directly in an Ethernet frame that an ethertype filter entry recognises. The transmit side stamps frames that are marked for stamping. The packet fields are assumed to be extracted upstream.

Top module: `pts_latch_top`

## Requirements
- R1: After reset both valid flags are 0 and both stamp outputs are 0.
- R2: When a side is unlocked and a qualifying start-of-frame strobe is high at a rising edge, that side's stamp takes the time counter value present at that edge and its valid flag is 1 from that edge on.
- R3: While a side's valid flag is 1, qualifying frames on that side change neither the stamp nor the flag.
- R4: A high-word read strobe while valid clears the flag at that edge and leaves the stamp unchanged; a read strobe while not valid has no effect.
- R5: A qualifying frame in the same cycle as the releasing read is not stamped; the flag ends at 0.
- R6: With the side's enable input low, no frame is stamped.
- R7: Receive mode 0 stamps only UDP frames whose destination port equals match word bits 31:16 (319 for the event port), whose version flag is 0 (version 1), and whose message type equals match word bits 3:0 (Sync = 0, Delay_Req = 1).
- R8: Receive mode 1 stamps version-2 frames (version flag 1) whose message type is 0 to 3 (Sync, Delay_Req, Pdelay_Req, Pdelay_Resp), reached either through the UDP port match or the ethertype filter; types 4 and above and version-1 frames are not stamped.
- R9: The ethertype filter word matches a non-UDP frame when bit 31 (filter enable) and bit 30 (stamp enable) are both 1 and the frame ethertype equals bits 15:0 (0x88F7); if either bit is 0 the filter matches nothing.
- R10: Receive modes 2 and 3 are reserved and stamp nothing.
- R11: The transmit side stamps a start-of-frame only when its mark input is high, and locks and releases independently of the receive side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_cnt | input | TS_W | Free-running time counter |
| rx_en | input | 1 | Receive stamping enable |
| rx_mode | input | 2 | Receive qualification mode |
| rx_match_cfg | input | 32 | Event port (31:16) and version-1 message type (3:0) |
| rx_etf_cfg | input | 32 | Ethertype filter: enables in 31/30, ethertype in 15:0 |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_is_udp | input | 1 | Frame is UDP |
| rx_dport | input | 16 | UDP destination port |
| rx_etype | input | 16 | Frame ethertype |
| rx_is_v2 | input | 1 | Version flag: 1 for version 2 |
| rx_msg_type | input | MSG_W | Message type field |
| rx_rd_hi | input | 1 | Receive stamp high-word read strobe |
| rx_stamp | output | TS_W | Receive stamp |
| rx_valid | output | 1 | Receive stamp valid (lock) |
| tx_en | input | 1 | Transmit stamping enable |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Frame requests a stamp |
| tx_rd_hi | input | 1 | Transmit stamp high-word read strobe |
| tx_stamp | output | TS_W | Transmit stamp |
| tx_valid | output | 1 | Transmit stamp valid (lock) |

## Verification
The two functions that can meet in one cycle are the release of the lock by a high-word read and the arrival of a new qualifying frame. The bench drives both strobes in the same cycle while a stamp is held and judges the result by the flag being low afterwards and by no stamp appearing in the scoreboard for that frame. A following qualifying frame must then be stamped with its own counter value, which shows the release took effect.

// File: rtl/pts_pkg.sv
package pts_pkg;

   typedef enum logic [1:0] {
      RXM_V1_L4  = 2'd0,
      RXM_V2_EVT = 2'd1,
      RXM_RSV2   = 2'd2,
      RXM_RSV3   = 2'd3
   } rx_mode_e;

   // field positions in the match word
   localparam int MATCH_PORT_LSB = 16;
   localparam int MATCH_PORT_MSB = 31;

   // field positions in the ethertype filter word
   localparam int ETF_FLT_EN_BIT = 31;
   localparam int ETF_TS_EN_BIT  = 30;
   localparam int ETF_TYPE_MSB   = 15;

   // highest version-2 event message type
   localparam int V2_EVENT_LAST = 3;

   localparam logic [15:0] PTP_EVENT_PORT = 16'd319;
   localparam logic [15:0] PTP_ETHERTYPE  = 16'h88F7;

endpackage

// File: rtl/pts_rx_qual.sv
module pts_rx_qual
   import pts_pkg::*;
#(
   parameter int MSG_W     = 4,
   parameter bit L2_FILTER = 1'b1
) (
   input  rx_mode_e          mode,
   input  logic [31:0]       match_cfg,
   input  logic [31:0]       etf_cfg,
   input  logic              is_udp,
   input  logic [15:0]       dport,
   input  logic [15:0]       etype,
   input  logic              is_v2,
   input  logic [MSG_W-1:0]  msg_type,
   output logic              hit
);

   localparam logic [MSG_W-1:0] EVT_LIMIT = MSG_W'(V2_EVENT_LAST + 1);

   logic udp_hit;
   logic l2_hit;
   logic v1_hit;
   logic v2_hit;

   assign udp_hit = is_udp && (dport == match_cfg[MATCH_PORT_MSB:MATCH_PORT_LSB]);

   generate
      if (L2_FILTER) begin : g_l2
         logic unused_etf;
         assign l2_hit = !is_udp && etf_cfg[ETF_FLT_EN_BIT] && etf_cfg[ETF_TS_EN_BIT]
                         && (etype == etf_cfg[ETF_TYPE_MSB:0]);
         assign unused_etf = ^etf_cfg[ETF_TS_EN_BIT-1:ETF_TYPE_MSB+1];
      end else begin : g_no_l2
         logic unused_etf;
         assign l2_hit = 1'b0;
         assign unused_etf = ^{etf_cfg, etype};
      end
   endgenerate

   logic unused_match;
   assign unused_match = ^match_cfg[MATCH_PORT_LSB-1:MSG_W];

   assign v1_hit = udp_hit && !is_v2 && (msg_type == match_cfg[MSG_W-1:0]);
   assign v2_hit = is_v2 && (msg_type < EVT_LIMIT) && (udp_hit || l2_hit);

   always_comb begin
      case (mode)
         RXM_V1_L4:  hit = v1_hit;
         RXM_V2_EVT: hit = v2_hit;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/pts_lock_latch.sv
module pts_lock_latch #(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] time_in,
   input  logic            cap_req,
   input  logic            rd_hi,
   output logic [TS_W-1:0] stamp,
   output logic            valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stamp <= '0;
         valid <= 1'b0;
      end else if (valid) begin
         if (rd_hi) valid <= 1'b0;
      end else if (cap_req) begin
         stamp <= time_in;
         valid <= 1'b1;
      end
   end

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && cap_req) |=> (valid && stamp == $past(time_in)));

   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd_hi) |=> (valid && $stable(stamp)));

   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && rd_hi) |=> (!valid && $stable(stamp)));

   a_r4_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !cap_req) |=> (!valid && $stable(stamp)));

endmodule

// File: rtl/pts_latch_top.sv
module pts_latch_top
   import pts_pkg::*;
#(
   parameter int TS_W      = 64,
   parameter int MSG_W     = 4,
   parameter bit L2_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  time_cnt,
   input  logic             rx_en,
   input  logic [1:0]       rx_mode,
   input  logic [31:0]      rx_match_cfg,
   input  logic [31:0]      rx_etf_cfg,
   input  logic             rx_sof,
   input  logic             rx_is_udp,
   input  logic [15:0]      rx_dport,
   input  logic [15:0]      rx_etype,
   input  logic             rx_is_v2,
   input  logic [MSG_W-1:0] rx_msg_type,
   input  logic             rx_rd_hi,
   output logic [TS_W-1:0]  rx_stamp,
   output logic             rx_valid,
   input  logic             tx_en,
   input  logic             tx_sof,
   input  logic             tx_mark,
   input  logic             tx_rd_hi,
   output logic [TS_W-1:0]  tx_stamp,
   output logic             tx_valid
);

   generate
      if (TS_W < 2 || TS_W > 128) begin : g_bad_ts_w
         $error("pts_latch_top: TS_W must lie in 2..128");
      end
      if (MSG_W < 3 || MSG_W > 16) begin : g_bad_msg_w
         $error("pts_latch_top: MSG_W must lie in 3..16");
      end
   endgenerate

   logic rx_hit;
   logic rx_cap;
   logic tx_cap;

   pts_rx_qual #(
      .MSG_W     (MSG_W),
      .L2_FILTER (L2_FILTER)
   ) u_qual (
      .mode      (rx_mode_e'(rx_mode)),
      .match_cfg (rx_match_cfg),
      .etf_cfg   (rx_etf_cfg),
      .is_udp    (rx_is_udp),
      .dport     (rx_dport),
      .etype     (rx_etype),
      .is_v2     (rx_is_v2),
      .msg_type  (rx_msg_type),
      .hit       (rx_hit)
   );

   assign rx_cap = rx_en && rx_sof && rx_hit;
   assign tx_cap = tx_en && tx_sof && tx_mark;

   pts_lock_latch #(.TS_W(TS_W)) u_rx_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .time_in (time_cnt),
      .cap_req (rx_cap),
      .rd_hi   (rx_rd_hi),
      .stamp   (rx_stamp),
      .valid   (rx_valid)
   );

   pts_lock_latch #(.TS_W(TS_W)) u_tx_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .time_in (time_cnt),
      .cap_req (tx_cap),
      .rd_hi   (tx_rd_hi),
      .stamp   (tx_stamp),
      .valid   (tx_valid)
   );

   a_r6_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rx_valid) |=> !rx_valid);

   a_r10_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mode[1] && !rx_valid) |=> !rx_valid);

   a_r11_tx_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_mark && !tx_valid) |=> !tx_valid);

   a_r5_no_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_rd_hi) |=> !rx_valid);

endmodule

// File: tb/sim_pts_latch_top.sv
module sim_pts_latch_top;
   import pts_pkg::*;

   localparam int TS_W  = 64;
   localparam int MSG_W = 4;
   localparam logic [63:0] TINC = 64'h0000_0001_0000_0007;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TS_W-1:0]  time_cnt = 64'h0000_00A0_0000_0000;
   logic             rx_en = 1'b0;
   logic [1:0]       rx_mode = 2'd0;
   logic [31:0]      rx_match_cfg = '0;
   logic [31:0]      rx_etf_cfg = '0;
   logic             rx_sof = 1'b0;
   logic             rx_is_udp = 1'b0;
   logic [15:0]      rx_dport = '0;
   logic [15:0]      rx_etype = '0;
   logic             rx_is_v2 = 1'b0;
   logic [MSG_W-1:0] rx_msg_type = '0;
   logic             rx_rd_hi = 1'b0;
   logic [TS_W-1:0]  rx_stamp;
   logic             rx_valid;
   logic             tx_en = 1'b0;
   logic             tx_sof = 1'b0;
   logic             tx_mark = 1'b0;
   logic             tx_rd_hi = 1'b0;
   logic [TS_W-1:0]  tx_stamp;
   logic             tx_valid;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [TS_W-1:0] rx_q[$];
   logic [TS_W-1:0] tx_q[$];
   bit rx_lock = 1'b0;
   bit tx_lock = 1'b0;
   logic [TS_W-1:0] rx_last = '0;
   logic [TS_W-1:0] tx_last = '0;

   always #4 clk = ~clk;
   always @(posedge clk) time_cnt <= time_cnt + TINC;

   pts_latch_top #(.TS_W(TS_W), .MSG_W(MSG_W), .L2_FILTER(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt),
      .rx_en(rx_en), .rx_mode(rx_mode), .rx_match_cfg(rx_match_cfg),
      .rx_etf_cfg(rx_etf_cfg), .rx_sof(rx_sof), .rx_is_udp(rx_is_udp),
      .rx_dport(rx_dport), .rx_etype(rx_etype), .rx_is_v2(rx_is_v2),
      .rx_msg_type(rx_msg_type), .rx_rd_hi(rx_rd_hi),
      .rx_stamp(rx_stamp), .rx_valid(rx_valid),
      .tx_en(tx_en), .tx_sof(tx_sof), .tx_mark(tx_mark), .tx_rd_hi(tx_rd_hi),
      .tx_stamp(tx_stamp), .tx_valid(tx_valid)
   );

   task automatic chk(input string req, input logic [TS_W-1:0] act,
                      input logic [TS_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // expected qualification, written from R7..R10
   function automatic bit rx_expect(input bit udp, input logic [15:0] dport,
                                    input logic [15:0] et, input bit v2,
                                    input logic [MSG_W-1:0] msg);
      bit port_ok;
      bit l2_ok;
      port_ok = udp && (dport == rx_match_cfg[31:16]);
      l2_ok   = !udp && rx_etf_cfg[31] && rx_etf_cfg[30] && (et == rx_etf_cfg[15:0]);
      if (rx_mode == 2'd0) return port_ok && !v2 && (msg == rx_match_cfg[3:0]);
      if (rx_mode == 2'd1) return v2 && (msg < 4) && (port_ok || l2_ok);
      return 1'b0;
   endfunction

   // driver: one cycle of receive stimulus, pushes the predicted stamp
   task automatic rx_cycle(input bit sof, input bit rd, input bit udp,
                           input logic [15:0] dport, input logic [15:0] et,
                           input bit v2, input logic [MSG_W-1:0] msg);
      bit cap;
      @(negedge clk);
      rx_sof = sof; rx_rd_hi = rd; rx_is_udp = udp; rx_dport = dport;
      rx_etype = et; rx_is_v2 = v2; rx_msg_type = msg;
      cap = sof && rx_en && rx_expect(udp, dport, et, v2, msg) && !rx_lock;
      if (cap) begin
         rx_q.push_back(time_cnt);
         rx_last = time_cnt;
         rx_lock = 1'b1;
      end else if (rx_lock && rd) begin
         rx_lock = 1'b0;
      end
      @(negedge clk);
      rx_sof = 1'b0; rx_rd_hi = 1'b0;
   endtask

   task automatic rx_udp(input logic [15:0] dport, input bit v2,
                         input logic [MSG_W-1:0] msg);
      rx_cycle(1'b1, 1'b0, 1'b1, dport, 16'h0800, v2, msg);
   endtask

   task automatic rx_l2(input logic [15:0] et, input logic [MSG_W-1:0] msg);
      rx_cycle(1'b1, 1'b0, 1'b0, 16'd0, et, 1'b1, msg);
   endtask

   task automatic rx_read();
      rx_cycle(1'b0, 1'b1, 1'b0, 16'd0, 16'd0, 1'b0, '0);
   endtask

   task automatic tx_cycle(input bit sof, input bit mark, input bit rd);
      bit cap;
      @(negedge clk);
      tx_sof = sof; tx_mark = mark; tx_rd_hi = rd;
      cap = sof && mark && tx_en && !tx_lock;
      if (cap) begin
         tx_q.push_back(time_cnt);
         tx_last = time_cnt;
         tx_lock = 1'b1;
      end else if (tx_lock && rd) begin
         tx_lock = 1'b0;
      end
      @(negedge clk);
      tx_sof = 1'b0; tx_mark = 1'b0; tx_rd_hi = 1'b0;
   endtask

   // monitor: compares each new stamp against the scoreboard
   logic rx_v_d = 1'b0;
   logic tx_v_d = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid && !rx_v_d) begin
            if (rx_q.size() == 0) chk("R2 rx unexpected stamp", rx_stamp, '1);
            else chk("R2 rx stamp value", rx_stamp, rx_q.pop_front());
         end
         if (tx_valid && !tx_v_d) begin
            if (tx_q.size() == 0) chk("R11 tx unexpected stamp", tx_stamp, '1);
            else chk("R11 tx stamp value", tx_stamp, tx_q.pop_front());
         end
      end
      rx_v_d <= rx_valid;
      tx_v_d <= tx_valid;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rx_valid", 64'(rx_valid), 0);
      chk("R1 tx_valid", 64'(tx_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rx_stamp", rx_stamp, 0);
      chk("R1 tx_stamp", tx_stamp, 0);

      rx_en = 1'b1;
      rx_mode = 2'd0;
      rx_match_cfg = {PTP_EVENT_PORT, 12'd0, 4'd0};
      rx_etf_cfg = {1'b1, 1'b1, 14'd0, PTP_ETHERTYPE};

      // R7 / R2 version-1 Sync on the event port
      rx_udp(PTP_EVENT_PORT, 1'b0, 4'd0);
      chk("R2 rx_valid after capture", 64'(rx_valid), 1);
      // R3 locked: second Sync ignored
      rx_udp(PTP_EVENT_PORT, 1'b0, 4'd0);
      chk("R3 rx_valid held", 64'(rx_valid), 1);
      chk("R3 rx_stamp held", rx_stamp, rx_last);
      // R4 release keeps stamp
      rx_read();
      chk("R4 rx_valid cleared", 64'(rx_valid), 0);
      chk("R4 rx_stamp kept", rx_stamp, rx_last);
      rx_read();
      chk("R4 idle read", 64'(rx_valid), 0);
      chk("R4 idle read stamp", rx_stamp, rx_last);

      // R7 non-matching cases
      rx_udp(PTP_EVENT_PORT, 1'b0, 4'd1);
      chk("R7 other msg type", 64'(rx_valid), 0);
      rx_udp(16'd320, 1'b0, 4'd0);
      chk("R7 other port", 64'(rx_valid), 0);
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd0);
      chk("R7 version 2 in mode 0", 64'(rx_valid), 0);
      rx_match_cfg[3:0] = 4'd1;
      rx_udp(PTP_EVENT_PORT, 1'b0, 4'd1);
      chk("R7 Delay_Req match", 64'(rx_valid), 1);
      rx_read();

      // R8 version-2 event mode
      rx_mode = 2'd1;
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd2);
      chk("R8 Pdelay_Req", 64'(rx_valid), 1);
      rx_read();
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd3);
      chk("R8 Pdelay_Resp", 64'(rx_valid), 1);
      rx_read();
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd8);
      chk("R8 general type 8", 64'(rx_valid), 0);
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd4);
      chk("R8 type 4", 64'(rx_valid), 0);
      rx_udp(PTP_EVENT_PORT, 1'b0, 4'd1);
      chk("R8 version 1 in mode 1", 64'(rx_valid), 0);

      // R9 ethertype filter
      rx_l2(PTP_ETHERTYPE, 4'd0);
      chk("R9 layer-2 Sync", 64'(rx_valid), 1);
      rx_read();
      rx_etf_cfg[30] = 1'b0;
      rx_l2(PTP_ETHERTYPE, 4'd0);
      chk("R9 stamp enable off", 64'(rx_valid), 0);
      rx_etf_cfg[30] = 1'b1;
      rx_etf_cfg[31] = 1'b0;
      rx_l2(PTP_ETHERTYPE, 4'd1);
      chk("R9 filter enable off", 64'(rx_valid), 0);
      rx_etf_cfg[31] = 1'b1;
      rx_l2(16'h0800, 4'd0);
      chk("R9 other ethertype", 64'(rx_valid), 0);

      // R5 read and frame in the same cycle
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd1);
      chk("R5 pre-lock", 64'(rx_valid), 1);
      rx_cycle(1'b1, 1'b1, 1'b1, PTP_EVENT_PORT, 16'h0800, 1'b1, 4'd0);
      chk("R5 frame at release dropped", 64'(rx_valid), 0);
      chk("R5 stamp not replaced", rx_stamp, rx_last);
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd0);
      chk("R5 next frame stamped", 64'(rx_valid), 1);
      rx_read();

      // R6 enable low
      rx_en = 1'b0;
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd0);
      chk("R6 disabled", 64'(rx_valid), 0);
      rx_en = 1'b1;

      // R10 reserved modes
      rx_mode = 2'd2;
      rx_udp(PTP_EVENT_PORT, 1'b1, 4'd0);
      chk("R10 mode 2", 64'(rx_valid), 0);
      rx_mode = 2'd3;
      rx_l2(PTP_ETHERTYPE, 4'd0);
      chk("R10 mode 3", 64'(rx_valid), 0);

      // R11 transmit side
      tx_en = 1'b1;
      tx_cycle(1'b1, 1'b0, 1'b0);
      chk("R11 unmarked", 64'(tx_valid), 0);
      tx_cycle(1'b1, 1'b1, 1'b0);
      chk("R11 marked", 64'(tx_valid), 1);
      chk("R11 rx untouched", 64'(rx_valid), 0);
      tx_cycle(1'b1, 1'b1, 1'b0);
      chk("R11 locked stamp", tx_stamp, tx_last);
      tx_cycle(1'b0, 1'b0, 1'b1);
      chk("R11 released", 64'(tx_valid), 0);
      tx_en = 1'b0;
      tx_cycle(1'b1, 1'b1, 1'b0);
      chk("R6 tx disabled", 64'(tx_valid), 0);

      repeat (3) @(negedge clk);
      chk("R2 rx scoreboard empty", 64'(rx_q.size()), 0);
      chk("R11 tx scoreboard empty", 64'(tx_q.size()), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule